// File: doc/BRIEF.md
# Locked-Update Pulse-Width Modulator

A single-channel pulse-width modulator with a four-word, 32-bit register window. A cycle counter, clocked by the block clock, produces a left-aligned waveform. Period and duty are given in clock cycles. The output sits at its duty-phase level while the counter is below the duty value. For the rest of the period it sits at the idle level. The duty-phase level and the idle level are set by two separate control bits, so software can run either polarity.

A written period, duty or polarity is first staged. It reaches the waveform only at a period boundary, so the output never shows a cut-short or doubled pulse. Software can also set a hold bit. While the hold bit is set, staged values are kept back however many boundaries pass. When the bit is cleared, the new period, duty and polarity all take effect together at the next boundary. A channel that is not running keeps its counter at zero and drives the idle level.

Top module: `pwm_lock_gen`

## Requirements
- R1: After reset, the period, duty, control and counter words all read 0 and the output is low.
- R2: The word at byte offset 0x4 holds the period, 0x8 the duty and 0xC the control word. Each reads back the last value written, from the cycle after the write. The word at 0x0 returns the live counter. Writing to 0x0 changes no register and has no effect on the waveform.
- R3: The channel runs only when control bit 0 and control bit 1 are both 1. Otherwise the counter is held at 0 and the output drives the idle level. After a write that starts the channel, the counter starts from 0 on the second rising edge.
- R4: While the channel runs with a period P > 0, the counter steps 0, 1, ..., P-1 and then returns to 0. The output is at the duty-phase level while the counter is below the duty value D, and at the idle level otherwise.
- R5: If D >= P, the output stays at the duty-phase level for the whole period. If P = 0, the counter stays at 0 and the output stays at the idle level.
- R6: With the hold bit clear, a new period, duty or polarity written while the channel runs takes effect only on the edge where the counter leaves P-1. While the channel is stopped, staged values take effect on the next edge.
- R7: While control bit 6 (hold) is 1, writes to period and duty are stored and read back, but the waveform keeps its previous period, duty and levels.
- R8: After the hold bit is cleared, the staged period, duty and both levels take effect together at the next period boundary.
- R9: Control bit 3 gives the duty-phase level and bit 4 gives the idle level (1 = high). Bits 5 and 8 are stored and read back only; 0 there means left-aligned output and no low-power mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the counting clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 4 | Byte address; bits 3:2 pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
A write lands in its register on its own clock edge, so the readback is due in the cycle after that edge. A change to the waveform appears only in the cycle after the commit edge. The commit edge is the edge after the write while the channel is stopped. While it runs, it is the first edge where the counter leaves P-1 with the hold bit clear. Starting the channel needs two edges: one to latch the control word and one to start the counter. The bench keeps a per-cycle model that advances on each rising edge with these latencies. It compares the output and the addressed read word on every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/pwm_lock_pkg.sv
package pwm_lock_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_DUTY   = 2'd2,
        SEL_CTRL   = 2'd3
    } reg_sel_e;

    // control word bit positions
    localparam int CB_ENABLE   = 0;
    localparam int CB_CONT     = 1;
    localparam int CB_ACT_HIGH = 3;
    localparam int CB_IDLE_HI  = 4;
    localparam int CB_HOLD     = 6;

    typedef struct packed {
        word_t period;
        word_t duty;
        logic  act_lvl;
        logic  idle_lvl;
    } wave_cfg_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a[3:2]);
    endfunction

    function automatic logic ctrl_running(input word_t c);
        return c[CB_ENABLE] & c[CB_CONT];
    endfunction

    function automatic wave_cfg_t pack_cfg(input word_t p, input word_t d, input word_t c);
        wave_cfg_t r;
        r.period   = p;
        r.duty     = d;
        r.act_lvl  = c[CB_ACT_HIGH];
        r.idle_lvl = c[CB_IDLE_HI];
        return r;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    input  word_t             count_val,
    output word_t             rdata,
    output word_t             period_q,
    output word_t             duty_q,
    output word_t             ctrl_q
);

    reg_sel_e sel;
    assign sel = decode_sel(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            duty_q   <= '0;
            ctrl_q   <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_PERIOD: period_q <= wdata;
                SEL_DUTY:   duty_q   <= wdata;
                SEL_CTRL:   ctrl_q   <= wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_COUNT:  rdata = count_val;
            SEL_PERIOD: rdata = period_q;
            SEL_DUTY:   rdata = duty_q;
            default:    rdata = ctrl_q;
        endcase
    end

    assert_count_word_ro_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_COUNT) |=>
            ($stable(period_q) && $stable(duty_q) && $stable(ctrl_q)));

    assert_period_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_PERIOD) |=> (period_q == $past(wdata)));

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
    import pwm_lock_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wave_cfg_t staged_cfg,
    input  logic      hold,
    input  logic      run_q,
    input  logic      wrap,
    output wave_cfg_t active_cfg
);

    logic commit;
    assign commit = !hold && (!run_q || wrap);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_cfg <= '0;
        end else if (commit) begin
            active_cfg <= staged_cfg;
        end
    end

    assert_hold_freezes_R7: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(active_cfg));

    assert_no_mid_period_change_R6: assert property (@(posedge clk) disable iff (rst)
        (run_q && !wrap) |=> $stable(active_cfg));

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
    import pwm_lock_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      running,
    input  wave_cfg_t active_cfg,
    output word_t     count,
    output logic      run_q,
    output logic      wrap,
    output logic      pwm_out
);

    assign wrap = run_q && ((active_cfg.period == '0) ||
                            (count == active_cfg.period - 1'b1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            run_q <= 1'b0;
        end else begin
            run_q <= running;
            if (!running || !run_q || wrap) begin
                count <= '0;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    always_comb begin
        if (run_q && (active_cfg.period != '0) && (count < active_cfg.duty)) begin
            pwm_out = active_cfg.act_lvl;
        end else begin
            pwm_out = active_cfg.idle_lvl;
        end
    end

    assert_count_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        (run_q && active_cfg.period != '0) |-> (count < active_cfg.period));

    assert_stop_clears_count_R3: assert property (@(posedge clk) disable iff (rst)
        !running |=> (count == '0));

    assert_stopped_count_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> (count == '0));

endmodule

// File: rtl/pwm_lock_gen.sv
module pwm_lock_gen
    import pwm_lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);

    word_t     period_q, duty_q, ctrl_q, count;
    wave_cfg_t staged_cfg, active_cfg;
    logic      run_q, wrap, running;

    pwm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .count_val (count),
        .rdata     (bus_rdata),
        .period_q  (period_q),
        .duty_q    (duty_q),
        .ctrl_q    (ctrl_q)
    );

    assign staged_cfg = pack_cfg(period_q, duty_q, ctrl_q);
    assign running    = ctrl_running(ctrl_q);

    pwm_shadow u_shadow (
        .clk        (clk),
        .rst        (rst),
        .staged_cfg (staged_cfg),
        .hold       (ctrl_q[CB_HOLD]),
        .run_q      (run_q),
        .wrap       (wrap),
        .active_cfg (active_cfg)
    );

    pwm_wave u_wave (
        .clk        (clk),
        .rst        (rst),
        .running    (running),
        .active_cfg (active_cfg),
        .count      (count),
        .run_q      (run_q),
        .wrap       (wrap),
        .pwm_out    (pwm_out)
    );

    assert_reset_out_low_R1: assert property (@(posedge clk)
        rst |=> (!pwm_out && count == '0));

endmodule

// File: tb/pwm_lock_gen_tb_top.sv
module pwm_lock_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    wire  [31:0] bus_rdata;
    wire         pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pwm_lock_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // cycle model built from the requirements
    logic [31:0] m_per, m_duty, m_ctrl, m_cnt, a_per, a_duty;
    logic        m_run, a_hi, a_lo;

    always @(posedge clk) begin
        logic run_now, wrapping;
        if (rst) begin
            m_per <= '0; m_duty <= '0; m_ctrl <= '0; m_cnt <= '0;
            a_per <= '0; a_duty <= '0; a_hi <= 1'b0; a_lo <= 1'b0; m_run <= 1'b0;
        end else begin
            run_now  = m_ctrl[0] && m_ctrl[1];
            wrapping = m_run && (a_per == 0 || m_cnt == a_per - 1);
            if (!m_ctrl[6] && (!m_run || wrapping)) begin
                a_per <= m_per; a_duty <= m_duty; a_hi <= m_ctrl[3]; a_lo <= m_ctrl[4];
            end
            m_cnt <= (!run_now || !m_run || wrapping) ? 32'd0 : m_cnt + 1;
            m_run <= run_now;
            if (bus_wr) begin
                case (bus_addr[3:2])
                    2'd1: m_per  <= bus_wdata;
                    2'd2: m_duty <= bus_wdata;
                    2'd3: m_ctrl <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic exp_out();
        return (m_run && a_per != 0 && m_cnt < a_duty) ? a_hi : a_lo;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a[3:2])
            2'd0: return m_cnt;
            2'd1: return m_per;
            2'd2: return m_duty;
            default: return m_ctrl;
        endcase
    endfunction

    task automatic chk_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_now(input string req);
        chk_val({req, " out"}, {31'd0, pwm_out}, {31'd0, exp_out()});
        chk_val({req, " rdata"}, bus_rdata, exp_rd(bus_addr));
    endtask

    task automatic tick(input string req);
        @(posedge clk);
        @(negedge clk);
        check_now(req);
    endtask

    task automatic run_for(input int n, input string req);
        for (int i = 0; i < n; i++) tick(req);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string req);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick(req);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        chk_val(req, bus_rdata, exp);
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        for (int a = 0; a < 4; a++) peek(4'(a * 4), 32'd0, "R1 reset word");
        chk_val("R1 reset out", {31'd0, pwm_out}, 32'd0);

        // R2: readback and read-only counter word
        wr(4'h4, 32'd7, "R2");
        wr(4'h8, 32'd3, "R2");
        wr(4'h0, 32'hFFFF, "R2");
        peek(4'h4, 32'd7, "R2 period readback");
        peek(4'h8, 32'd3, "R2 duty readback");
        peek(4'h0, 32'd0, "R2 counter ignores write");
        peek(4'hC, 32'd0, "R2 ctrl untouched");

        // R3: enable without continuous bit stays idle, idle high
        wr(4'hC, 32'h11, "R3");
        run_for(5, "R3");
        chk_val("R3 idle level while stopped", {31'd0, pwm_out}, 32'd1);
        peek(4'h0, 32'd0, "R3 counter held");

        // R4: normal run, period 7 duty 3, counter observed
        wr(4'hC, 32'h0B, "R4");
        tick("R3 start latency");
        run_for(20, "R4");

        // R9: inverted polarity and stored-only bits 5 and 8
        wr(4'hC, 32'h133, "R9");
        peek(4'hC, 32'h133, "R9 ctrl readback");
        run_for(20, "R9");
        wr(4'hC, 32'h13, "R9");
        run_for(10, "R9");

        // R5: duty at/above period, then period zero
        wr(4'h8, 32'd20, "R5");
        run_for(16, "R5");
        wr(4'h4, 32'd0, "R5");
        run_for(6, "R5");

        // R6: mid-period duty change waits for boundary
        wr(4'hC, 32'h0B, "R6");
        wr(4'h4, 32'd10, "R6");
        wr(4'h8, 32'd5, "R6");
        run_for(13, "R6");
        wr(4'h8, 32'd8, "R6");
        run_for(22, "R6");

        // R7: hold bit freezes waveform
        wr(4'hC, 32'h4B, "R7");
        wr(4'h4, 32'd4, "R7");
        wr(4'h8, 32'd1, "R7");
        peek(4'h4, 32'd4, "R7 held period readback");
        run_for(25, "R7");

        // R8: release with polarity change
        wr(4'hC, 32'h13, "R8");
        run_for(20, "R8");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 5) == 0) begin
                logic [3:0]  a;
                logic [31:0] d;
                a = 4'($urandom_range(0, 3) * 4);
                case (a[3:2])
                    2'd1: d = $urandom_range(0, 9);
                    2'd2: d = $urandom_range(0, 11);
                    2'd3: begin
                        d = $urandom & 32'h0000_0158;
                        if ($urandom_range(0, 6) != 0) d[1:0] = 2'b11;
                        else d[1:0] = 2'($urandom);
                        if ($urandom_range(0, 2) == 0) d[6] = 1'b1;
                    end
                    default: d = $urandom;
                endcase
                wr(a, d, "R4 random");
            end else begin
                bus_addr = 4'($urandom_range(0, 3) * 4);
                tick("R8 random");
            end
        end

        done = 1'b1;
        report();
    end

endmodule